// File: doc/BRIEF.md
# Hybrid Directory Coherence Sequencer

This block sits beside a shared memory-side cache and keeps, for every cache line, a record of which first-level caches hold a copy. While few copies exist, a line keeps an exact list of holders, each entry being a source id plus an instruction/data type bit. Once the number of copies passes a threshold, the line drops the list and keeps only a count. A write to a listed line turns into one targeted update per holder other than the writer itself. A write to a counted line, or an eviction of one, turns into a single broadcast invalidate. An eviction of a listed line sends one invalidate per holder.

Requests arrive on one port: write, read-registration, cleanup or evict, each with a line index, a source id and a type bit. The sequencer writes the new directory state for the line when it accepts the request. It then issues coherence commands one per cycle and loads a pending-response counter with the number of acknowledgements it must collect. Only when that counter is empty does it raise a one-cycle done pulse carrying the operation and the line. New requests are refused from acceptance until the done pulse.

The control is a four-state machine. IDLE accepts a request. It moves to ISSUE when commands are needed and to DONE otherwise. ISSUE emits one command per cycle and moves to WAIT after the last one, or straight after the single broadcast. WAIT stays until the pending counter reads zero and then moves to DONE. DONE pulses the done output and returns to IDLE.

Top module: `coh_dir_seq`

## Requirements
- R1: While reset is held and on the first cycle after it, req_ready is 1, cmd_valid is 0 and done_valid is 0.
- R2: A read-registration (op code 1) on a listed line adds one entry for a source id and type pair that is not yet present. A pair already present is ignored. The same source with type 0 (data) and type 1 (instruction) gives two separate entries. The request completes with no commands.
- R3: A write (op code 0) to a listed line issues one update command (kind code 0) for every entry except the one whose source id and type both equal the writer's. Commands go out on consecutive cycles, lowest storage slot first, and slots fill lowest free first.
- R4: Every command carries the request's line index. An update is nwords+2 flits long. Every invalidate (kind code 1) and broadcast (kind code 2) is 1 flit long.
- R5: A line keeps a list for up to THRESH copies. The registration that would make THRESH+1 copies switches the line to count mode.
- R6: A write or evict to a line in count mode issues exactly one broadcast command with destination 0. Completion then waits for as many responses as the stored count, and the line ends empty in list mode.
- R7: An evict (op code 3) to a listed line issues one invalidate per entry, in slot order, and leaves the line empty.
- R8: A cleanup (op code 2) removes the matching source/type entry in list mode and is ignored when no entry matches. In count mode it decrements the count, and the line stays in count mode until the count reaches zero, when it returns to an empty list.
- R9: done_valid is a single-cycle pulse carrying the request's op and line. It is raised only after every expected response has been received.
- R10: req_ready is 0 from the cycle after acceptance until the done pulse.
- R11: A write to a listed line with no copy other than the writer's completes with no command and no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request taken this cycle |
| req_op | input | 2 | 0 write, 1 read-registration, 2 cleanup, 3 evict |
| req_line | input | LINE_W | Directory line index |
| req_src | input | SRC_W | Requesting cache source id |
| req_ity | input | 1 | Copy type: 0 data, 1 instruction |
| req_nwords | input | NW_W | Data words carried by a write |
| cmd_valid | output | 1 | Coherence command issued this cycle |
| cmd_kind | output | 2 | 0 update, 1 invalidate, 2 broadcast invalidate |
| cmd_line | output | LINE_W | Line addressed by the command |
| cmd_dst | output | SRC_W | Destination source id (0 for broadcast) |
| cmd_ity | output | 1 | Destination copy type |
| cmd_flits | output | NW_W+1 | Command packet length in flits |
| rsp_valid | input | 1 | One coherence acknowledgement |
| done_valid | output | 1 | Request completed |
| done_op | output | 2 | Op of the completed request |
| done_line | output | LINE_W | Line of the completed request |

## Verification
The assertions assume that acknowledgements arrive only while commands are outstanding, never while idle, and never before the command they answer has been issued. They also assume a request is presented only while req_ready is high. The directed bench waits until it has seen every command of a transaction before driving responses, sends exactly the number each scenario expects, and raises a request only when the sequencer is idle. Every scenario uses its own line, so earlier scenarios leave no state behind in the lines that later ones read.

// File: rtl/coh_pkg.sv
package coh_pkg;
    typedef enum logic [1:0] {
        OP_WRITE   = 2'd0,
        OP_READ    = 2'd1,
        OP_CLEANUP = 2'd2,
        OP_EVICT   = 2'd3
    } coh_op_e;

    typedef enum logic [1:0] {
        CK_UPDATE = 2'd0,
        CK_INVAL  = 2'd1,
        CK_BCAST  = 2'd2
    } coh_kind_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_ISSUE,
        S_WAIT,
        S_DONE
    } seq_state_e;
endpackage

// File: rtl/coh_dir_store.sv
// Per-line directory state: mode bit, copy count and sharer slots.
module coh_dir_store #(
    parameter int NLINES = 8,
    parameter int LINE_W = 3,
    parameter int NSLOT  = 4,
    parameter int SRC_W  = 4,
    parameter int CNT_W  = 6
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [LINE_W-1:0]            line,
    output logic                         cur_cmode,
    output logic [CNT_W-1:0]             cur_cnt,
    output logic [NSLOT-1:0]             cur_vld,
    output logic [NSLOT-1:0][SRC_W-1:0]  cur_src,
    output logic [NSLOT-1:0]             cur_ity,
    input  logic                         wr_en,
    input  logic                         nxt_cmode,
    input  logic [CNT_W-1:0]             nxt_cnt,
    input  logic [NSLOT-1:0]             nxt_vld,
    input  logic [NSLOT-1:0][SRC_W-1:0]  nxt_src,
    input  logic [NSLOT-1:0]             nxt_ity
);
    logic                        cmode_q [NLINES];
    logic [CNT_W-1:0]            cnt_q   [NLINES];
    logic [NSLOT-1:0]            vld_q   [NLINES];
    logic [NSLOT-1:0][SRC_W-1:0] src_q   [NLINES];
    logic [NSLOT-1:0]            ity_q   [NLINES];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int l = 0; l < NLINES; l++) begin
                cmode_q[l] <= 1'b0;
                cnt_q[l]   <= '0;
                vld_q[l]   <= '0;
                src_q[l]   <= '0;
                ity_q[l]   <= '0;
            end
        end else if (wr_en) begin
            cmode_q[line] <= nxt_cmode;
            cnt_q[line]   <= nxt_cnt;
            vld_q[line]   <= nxt_vld;
            src_q[line]   <= nxt_src;
            ity_q[line]   <= nxt_ity;
        end
    end

    assign cur_cmode = cmode_q[line];
    assign cur_cnt   = cnt_q[line];
    assign cur_vld   = vld_q[line];
    assign cur_src   = src_q[line];
    assign cur_ity   = ity_q[line];
endmodule

// File: rtl/coh_dir_update.sv
// Combinational directory update: next line state, targets, expected responses.
module coh_dir_update
    import coh_pkg::*;
#(
    parameter int NSLOT = 4,
    parameter int SRC_W = 4,
    parameter int CNT_W = 6
) (
    input  coh_op_e                      req_op,
    input  logic [SRC_W-1:0]             req_src,
    input  logic                         req_ity,
    input  logic                         cur_cmode,
    input  logic [CNT_W-1:0]             cur_cnt,
    input  logic [NSLOT-1:0]             cur_vld,
    input  logic [NSLOT-1:0][SRC_W-1:0]  cur_src,
    input  logic [NSLOT-1:0]             cur_ity,
    output logic                         nxt_cmode,
    output logic [CNT_W-1:0]             nxt_cnt,
    output logic [NSLOT-1:0]             nxt_vld,
    output logic [NSLOT-1:0][SRC_W-1:0]  nxt_src,
    output logic [NSLOT-1:0]             nxt_ity,
    output logic [NSLOT-1:0]             tgt,
    output logic                         bcast,
    output logic [CNT_W-1:0]             n_rsp
);
    logic [NSLOT-1:0] hit;
    logic [NSLOT-1:0] free_oh;

    function automatic logic [CNT_W-1:0] ones(input logic [NSLOT-1:0] v);
        logic [CNT_W-1:0] c;
        c = '0;
        for (int i = 0; i < NSLOT; i++) c = c + CNT_W'(v[i]);
        return c;
    endfunction

    always_comb begin : slot_scan
        logic seen;
        seen    = 1'b0;
        free_oh = '0;
        for (int i = 0; i < NSLOT; i++) begin
            hit[i] = cur_vld[i] && (cur_src[i] == req_src) && (cur_ity[i] == req_ity);
            if (!cur_vld[i] && !seen) begin
                free_oh[i] = 1'b1;
                seen       = 1'b1;
            end
        end
    end

    always_comb begin
        nxt_cmode = cur_cmode;
        nxt_cnt   = cur_cnt;
        nxt_vld   = cur_vld;
        nxt_src   = cur_src;
        nxt_ity   = cur_ity;
        tgt       = '0;
        bcast     = 1'b0;
        n_rsp     = '0;
        unique case (req_op)
            OP_WRITE, OP_EVICT: begin
                if (cur_cmode) begin
                    bcast = 1'b1;
                    n_rsp = cur_cnt;
                end else begin
                    tgt   = (req_op == OP_WRITE) ? (cur_vld & ~hit) : cur_vld;
                    n_rsp = ones(tgt);
                end
                if (cur_cmode || req_op == OP_EVICT) begin
                    nxt_cmode = 1'b0;
                    nxt_cnt   = '0;
                    nxt_vld   = '0;
                end
            end
            OP_READ: begin
                if (cur_cmode) begin
                    if (cur_cnt != {CNT_W{1'b1}}) nxt_cnt = cur_cnt + CNT_W'(1);
                end else if (|hit) begin
                    nxt_cnt = cur_cnt;
                end else if (|free_oh) begin
                    nxt_vld = cur_vld | free_oh;
                    nxt_cnt = cur_cnt + CNT_W'(1);
                    for (int i = 0; i < NSLOT; i++) begin
                        if (free_oh[i]) begin
                            nxt_src[i] = req_src;
                            nxt_ity[i] = req_ity;
                        end
                    end
                end else begin
                    nxt_cmode = 1'b1;
                    nxt_vld   = '0;
                    nxt_cnt   = cur_cnt + CNT_W'(1);
                end
            end
            OP_CLEANUP: begin
                if (cur_cmode) begin
                    if (cur_cnt != '0) nxt_cnt = cur_cnt - CNT_W'(1);
                    if (cur_cnt <= CNT_W'(1)) nxt_cmode = 1'b0;
                end else if (|hit) begin
                    nxt_vld = cur_vld & ~hit;
                    nxt_cnt = cur_cnt - CNT_W'(1);
                end
            end
        endcase
    end
endmodule

// File: rtl/coh_ack_ctr.sv
// Pending-response counter: loaded on acceptance, decremented per acknowledgement.
module coh_ack_ctr #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic             zero
);
    logic [CNT_W-1:0] pend_q;

    always_ff @(posedge clk) begin
        if (!rst_n)                     pend_q <= '0;
        else if (load)                  pend_q <= load_val;
        else if (dec && pend_q != '0)   pend_q <= pend_q - CNT_W'(1);
    end

    assign zero = (pend_q == '0);
endmodule

// File: rtl/coh_dir_seq.sv
module coh_dir_seq
    import coh_pkg::*;
#(
    parameter int NLINES = 8,
    parameter int SRC_W  = 4,
    parameter int THRESH = 4,
    parameter int NW_W   = 4,
    localparam int LINE_W = $clog2(NLINES),
    localparam int FL_W   = NW_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_op,
    input  logic [LINE_W-1:0] req_line,
    input  logic [SRC_W-1:0]  req_src,
    input  logic              req_ity,
    input  logic [NW_W-1:0]   req_nwords,
    output logic              cmd_valid,
    output logic [1:0]        cmd_kind,
    output logic [LINE_W-1:0] cmd_line,
    output logic [SRC_W-1:0]  cmd_dst,
    output logic              cmd_ity,
    output logic [FL_W-1:0]   cmd_flits,
    input  logic              rsp_valid,
    output logic              done_valid,
    output logic [1:0]        done_op,
    output logic [LINE_W-1:0] done_line
);
    localparam int NSLOT = THRESH;
    localparam int CNT_W = $clog2(2 * (2 ** SRC_W) + 1);
    localparam int IDX_W = (NSLOT > 1) ? $clog2(NSLOT) : 1;

    seq_state_e state_q, state_d;
    coh_op_e    op_q;
    logic [LINE_W-1:0]           line_q;
    logic [NW_W-1:0]             nw_q;
    logic                        bcast_q;
    logic [NSLOT-1:0]            tmask_q;
    logic [NSLOT-1:0][SRC_W-1:0] tsrc_q;
    logic [NSLOT-1:0]            tity_q;

    logic                        cur_cmode, nxt_cmode;
    logic [CNT_W-1:0]            cur_cnt, nxt_cnt, n_rsp;
    logic [NSLOT-1:0]            cur_vld, nxt_vld, cur_ity, nxt_ity, tgt;
    logic [NSLOT-1:0][SRC_W-1:0] cur_src, nxt_src;
    logic                        bcast, ack_zero, accept;
    logic [NSLOT-1:0]            pick_oh;
    logic [IDX_W-1:0]            pick_idx;

    assign accept = (state_q == S_IDLE) && req_valid;

    coh_dir_store #(.NLINES(NLINES), .LINE_W(LINE_W), .NSLOT(NSLOT),
                    .SRC_W(SRC_W), .CNT_W(CNT_W)) i_store (
        .clk(clk), .rst_n(rst_n), .line(req_line),
        .cur_cmode(cur_cmode), .cur_cnt(cur_cnt), .cur_vld(cur_vld),
        .cur_src(cur_src), .cur_ity(cur_ity),
        .wr_en(accept), .nxt_cmode(nxt_cmode), .nxt_cnt(nxt_cnt),
        .nxt_vld(nxt_vld), .nxt_src(nxt_src), .nxt_ity(nxt_ity));

    coh_dir_update #(.NSLOT(NSLOT), .SRC_W(SRC_W), .CNT_W(CNT_W)) i_update (
        .req_op(coh_op_e'(req_op)), .req_src(req_src), .req_ity(req_ity),
        .cur_cmode(cur_cmode), .cur_cnt(cur_cnt), .cur_vld(cur_vld),
        .cur_src(cur_src), .cur_ity(cur_ity),
        .nxt_cmode(nxt_cmode), .nxt_cnt(nxt_cnt), .nxt_vld(nxt_vld),
        .nxt_src(nxt_src), .nxt_ity(nxt_ity),
        .tgt(tgt), .bcast(bcast), .n_rsp(n_rsp));

    coh_ack_ctr #(.CNT_W(CNT_W)) i_ack (
        .clk(clk), .rst_n(rst_n), .load(accept), .load_val(n_rsp),
        .dec(rsp_valid), .zero(ack_zero));

    // Lowest pending target slot.
    always_comb begin : pick_low
        logic seen;
        seen     = 1'b0;
        pick_oh  = '0;
        pick_idx = '0;
        for (int i = 0; i < NSLOT; i++) begin
            if (tmask_q[i] && !seen) begin
                pick_oh[i] = 1'b1;
                pick_idx   = IDX_W'(i);
                seen       = 1'b1;
            end
        end
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (accept) state_d = (bcast || (|tgt)) ? S_ISSUE : S_DONE;
            S_ISSUE: if (bcast_q || ((tmask_q & ~pick_oh) == '0)) state_d = S_WAIT;
            S_WAIT:  if (ack_zero) state_d = S_DONE;
            S_DONE:  state_d = S_IDLE;
        endcase
    end

    // State register and transaction context.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            op_q    <= OP_WRITE;
            line_q  <= '0;
            nw_q    <= '0;
            bcast_q <= 1'b0;
            tmask_q <= '0;
            tsrc_q  <= '0;
            tity_q  <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                op_q    <= coh_op_e'(req_op);
                line_q  <= req_line;
                nw_q    <= req_nwords;
                bcast_q <= bcast;
                tmask_q <= tgt;
                tsrc_q  <= cur_src;
                tity_q  <= cur_ity;
            end else if (state_q == S_ISSUE && !bcast_q) begin
                tmask_q <= tmask_q & ~pick_oh;
            end
        end
    end

    // Outputs.
    always_comb begin
        req_ready  = 1'b0;
        cmd_valid  = 1'b0;
        cmd_kind   = CK_UPDATE;
        cmd_dst    = '0;
        cmd_ity    = 1'b0;
        cmd_flits  = FL_W'(1);
        done_valid = 1'b0;
        cmd_line   = line_q;
        done_op    = op_q;
        done_line  = line_q;
        unique case (state_q)
            S_IDLE:  req_ready = 1'b1;
            S_ISSUE: begin
                cmd_valid = 1'b1;
                if (bcast_q) begin
                    cmd_kind = CK_BCAST;
                end else begin
                    cmd_kind  = (op_q == OP_WRITE) ? CK_UPDATE : CK_INVAL;
                    cmd_dst   = tsrc_q[pick_idx];
                    cmd_ity   = tity_q[pick_idx];
                    if (op_q == OP_WRITE) cmd_flits = FL_W'(nw_q) + FL_W'(2);
                end
            end
            S_WAIT:  ;
            S_DONE:  done_valid = 1'b1;
        endcase
    end
endmodule

// File: rtl/coh_dir_seq_chk.sv
module coh_dir_seq_chk #(
    parameter int SRC_W  = 4,
    parameter int LINE_W = 3,
    parameter int NW_W   = 4,
    parameter int FL_W   = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [LINE_W-1:0] req_line,
    input logic [SRC_W-1:0]  req_src,
    input logic              req_ity,
    input logic [NW_W-1:0]   req_nwords,
    input logic              cmd_valid,
    input logic [1:0]        cmd_kind,
    input logic [LINE_W-1:0] cmd_line,
    input logic [SRC_W-1:0]  cmd_dst,
    input logic              cmd_ity,
    input logic [FL_W-1:0]   cmd_flits,
    input logic              rsp_valid,
    input logic              done_valid
);
    logic [SRC_W-1:0]  w_src_q;
    logic              w_ity_q;
    logic [LINE_W-1:0] l_q;
    logic [NW_W-1:0]   nw_q;
    logic              issued_q, rsp_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            w_src_q  <= '0;
            w_ity_q  <= 1'b0;
            l_q      <= '0;
            nw_q     <= '0;
            issued_q <= 1'b0;
            rsp_q    <= 1'b0;
        end else if (req_valid && req_ready) begin
            w_src_q  <= req_src;
            w_ity_q  <= req_ity;
            l_q      <= req_line;
            nw_q     <= req_nwords;
            issued_q <= 1'b0;
            rsp_q    <= 1'b0;
        end else begin
            if (cmd_valid) issued_q <= 1'b1;
            if (rsp_valid) rsp_q    <= 1'b1;
        end
    end

    a_r10_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |=> !done_valid);
    a_r9_done_after_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && issued_q) |-> rsp_q);
    a_r9_cmd_not_done: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> !done_valid);
    a_r3_skip_writer: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_kind == 2'd0) |-> !(cmd_dst == w_src_q && cmd_ity == w_ity_q));
    a_r4_line_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (cmd_line == l_q));
    a_r4_update_len: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_kind == 2'd0) |-> (cmd_flits == FL_W'(nw_q) + FL_W'(2)));
    a_r4_single_flit: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_kind != 2'd0) |-> (cmd_flits == FL_W'(1)));
    a_r6_bcast_alone: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_kind == 2'd2) |=> !cmd_valid);
endmodule

bind coh_dir_seq coh_dir_seq_chk #(
    .SRC_W(SRC_W), .LINE_W(LINE_W), .NW_W(NW_W), .FL_W(FL_W)
) i_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_line(req_line), .req_src(req_src), .req_ity(req_ity),
    .req_nwords(req_nwords), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
    .cmd_line(cmd_line), .cmd_dst(cmd_dst), .cmd_ity(cmd_ity),
    .cmd_flits(cmd_flits), .rsp_valid(rsp_valid), .done_valid(done_valid)
);

// File: tb/test_coh_dir_seq.sv
module test_coh_dir_seq;
    localparam int NLINES = 8;
    localparam int SRC_W  = 4;
    localparam int THRESH = 4;
    localparam int NW_W   = 4;
    localparam int LINE_W = $clog2(NLINES);
    localparam int FL_W   = NW_W + 1;

    localparam logic [1:0] OPW = 2'd0, OPR = 2'd1, OPC = 2'd2, OPE = 2'd3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [1:0]        req_op = '0;
    logic [LINE_W-1:0] req_line = '0;
    logic [SRC_W-1:0]  req_src = '0;
    logic              req_ity = 1'b0;
    logic [NW_W-1:0]   req_nwords = '0;
    logic              cmd_valid;
    logic [1:0]        cmd_kind;
    logic [LINE_W-1:0] cmd_line;
    logic [SRC_W-1:0]  cmd_dst;
    logic              cmd_ity;
    logic [FL_W-1:0]   cmd_flits;
    logic              rsp_valid = 1'b0;
    logic              done_valid;
    logic [1:0]        done_op;
    logic [LINE_W-1:0] done_line;

    coh_dir_seq #(.NLINES(NLINES), .SRC_W(SRC_W), .THRESH(THRESH), .NW_W(NW_W)) i_coh_dir_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_line(req_line), .req_src(req_src), .req_ity(req_ity),
        .req_nwords(req_nwords), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
        .cmd_line(cmd_line), .cmd_dst(cmd_dst), .cmd_ity(cmd_ity),
        .cmd_flits(cmd_flits), .rsp_valid(rsp_valid), .done_valid(done_valid),
        .done_op(done_op), .done_line(done_line));

    always #5 clk = ~clk;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;
    int got_n;
    int got_kind[16], got_dst[16], got_ity[16], got_flits[16], got_line[16];

    task automatic check(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    // Drive one request, then record the burst of commands that follows.
    task automatic do_op(input logic [1:0] op, input int line, input int src,
                         input int ity, input int nw);
        @(negedge clk);
        req_valid  = 1'b1;
        req_op     = op;
        req_line   = LINE_W'(line);
        req_src    = SRC_W'(src);
        req_ity    = ity[0];
        req_nwords = NW_W'(nw);
        @(negedge clk);
        req_valid = 1'b0;
        got_n = 0;
        while (cmd_valid && got_n < 16) begin
            got_kind[got_n]  = int'(cmd_kind);
            got_dst[got_n]   = int'(cmd_dst);
            got_ity[got_n]   = int'(cmd_ity);
            got_flits[got_n] = int'(cmd_flits);
            got_line[got_n]  = int'(cmd_line);
            check("R10 ready low while issuing", int'(req_ready), 0);
            got_n++;
            @(negedge clk);
        end
    endtask

    task automatic expect_cmd(input string tag, input int i, input int kind,
                              input int dst, input int ity, input int flits, input int line);
        check({tag, " kind"}, got_kind[i], kind);
        check({tag, " dst"}, got_dst[i], dst);
        check({tag, " type"}, got_ity[i], ity);
        check({"R4 ", tag, " flits"}, got_flits[i], flits);
        check({"R4 ", tag, " line"}, got_line[i], line);
    endtask

    task automatic send_rsp(input string tag, input int n);
        for (int r = 0; r < n; r++) begin
            check({"R9 ", tag, " no early done"}, int'(done_valid), 0);
            check({"R10 ", tag, " ready low while waiting"}, int'(req_ready), 0);
            rsp_valid = 1'b1;
            @(negedge clk);
        end
        rsp_valid = 1'b0;
    endtask

    task automatic wait_done(input string tag, input logic [1:0] op, input int line);
        int seen = 0;
        for (int i = 0; i < 8 && seen == 0; i++) begin
            if (done_valid) begin
                seen = 1;
                check({"R9 ", tag, " done op"}, int'(done_op), int'(op));
                check({"R9 ", tag, " done line"}, int'(done_line), line);
            end else begin
                @(negedge clk);
            end
        end
        check({"R9 ", tag, " done seen"}, seen, 1);
        @(negedge clk);
        check({"R9 ", tag, " done single pulse"}, int'(done_valid), 0);
    endtask

    task automatic reg_read(input int line, input int src, input int ity);
        do_op(OPR, line, src, ity, 0);
        check("R2 read issues no command", got_n, 0);
        wait_done("R2 read", OPR, line);
    endtask

    task automatic cleanup(input int line, input int src, input int ity);
        do_op(OPC, line, src, ity, 0);
        check("R8 cleanup issues no command", got_n, 0);
        wait_done("R8 cleanup", OPC, line);
    endtask

    task automatic t_reset();
        check("R1 reset ready", int'(req_ready), 1);
        check("R1 reset cmd", int'(cmd_valid), 0);
        check("R1 reset done", int'(done_valid), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 post-reset ready", int'(req_ready), 1);
        check("R1 post-reset cmd", int'(cmd_valid), 0);
        check("R1 post-reset done", int'(done_valid), 0);
    endtask

    task automatic t_multicast();
        reg_read(1, 1, 0);
        reg_read(1, 2, 0);
        reg_read(1, 2, 1);
        reg_read(1, 1, 0);   // duplicate, ignored
        do_op(OPW, 1, 1, 0, 3);
        check("R3 R2 update count", got_n, 2);
        expect_cmd("R3 upd0", 0, 0, 2, 0, 5, 1);
        expect_cmd("R3 R2 upd1", 1, 0, 2, 1, 5, 1);
        send_rsp("R3", 2);
        wait_done("R3 write", OPW, 1);
    endtask

    task automatic t_self_only();
        reg_read(0, 6, 0);
        do_op(OPW, 0, 6, 0, 1);
        check("R11 no commands", got_n, 0);
        wait_done("R11 write", OPW, 0);
    endtask

    task automatic t_full_list();
        for (int s = 4; s < 8; s++) reg_read(3, s, 0);
        do_op(OPW, 3, 9, 0, 0);
        check("R5 list at threshold count", got_n, 4);
        for (int i = 0; i < 4; i++) expect_cmd("R5 upd", i, 0, 4 + i, 0, 2, 3);
        send_rsp("R5", 4);
        wait_done("R5 write", OPW, 3);
    endtask

    task automatic t_broadcast();
        for (int s = 3; s < 8; s++) reg_read(2, s, 0);
        do_op(OPW, 2, 3, 0, 2);
        check("R6 R5 single broadcast", got_n, 1);
        expect_cmd("R6 bcast", 0, 2, 0, 0, 1, 2);
        send_rsp("R6", 5);
        wait_done("R6 write", OPW, 2);
        do_op(OPW, 2, 1, 0, 2);
        check("R6 line empty after broadcast", got_n, 0);
        wait_done("R6 empty write", OPW, 2);
    endtask

    task automatic t_evict_list();
        reg_read(4, 8, 0);
        reg_read(4, 8, 1);
        reg_read(4, 9, 0);
        do_op(OPE, 4, 0, 0, 5);
        check("R7 invalidate count", got_n, 3);
        expect_cmd("R7 inv0", 0, 1, 8, 0, 1, 4);
        expect_cmd("R7 inv1", 1, 1, 8, 1, 1, 4);
        expect_cmd("R7 inv2", 2, 1, 9, 0, 1, 4);
        send_rsp("R7", 3);
        wait_done("R7 evict", OPE, 4);
        do_op(OPW, 4, 10, 0, 1);
        check("R7 line empty after evict", got_n, 0);
        wait_done("R7 empty write", OPW, 4);
    endtask

    task automatic t_cleanup_list();
        reg_read(5, 1, 0);
        reg_read(5, 2, 0);
        reg_read(5, 3, 1);
        cleanup(5, 2, 0);
        cleanup(5, 2, 1);    // no matching entry, ignored
        do_op(OPW, 5, 4, 0, 1);
        check("R8 targets after cleanup", got_n, 2);
        expect_cmd("R8 upd0", 0, 0, 1, 0, 3, 5);
        expect_cmd("R8 upd1", 1, 0, 3, 1, 3, 5);
        send_rsp("R8", 2);
        wait_done("R8 write", OPW, 5);
    endtask

    task automatic t_cleanup_count();
        for (int s = 1; s < 7; s++) reg_read(6, s, 0);
        cleanup(6, 1, 0);
        cleanup(6, 2, 0);
        do_op(OPE, 6, 0, 0, 0);
        check("R8 count mode sticky", got_n, 1);
        expect_cmd("R8 R6 bcast", 0, 2, 0, 0, 1, 6);
        send_rsp("R8 R6", 4);
        wait_done("R6 evict", OPE, 6);
    endtask

    task automatic t_count_to_list();
        for (int s = 1; s < 6; s++) reg_read(7, s, 0);
        for (int s = 1; s < 6; s++) cleanup(7, s, 0);
        reg_read(7, 9, 0);
        do_op(OPW, 7, 2, 0, 0);
        check("R8 back to list", got_n, 1);
        expect_cmd("R8 list upd", 0, 0, 9, 0, 2, 7);
        send_rsp("R8 list", 1);
        wait_done("R8 list write", OPW, 7);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog (all requirements): actual 0 expected 1");
            report();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_multicast();
        t_self_only();
        t_full_list();
        t_broadcast();
        t_evict_list();
        t_cleanup_list();
        t_cleanup_count();
        t_count_to_list();
        finished = 1'b1;
        report();
        $finish;
    end
endmodule